// File: doc/BRIEF.md
# Converter Control Decode and Output Bus

This block is the digital front of a 12-bit successive-approximation converter. It watches five host-side control pins: chip enable, an active-low select, a read/convert line, a word-mode select and a byte-address line. From them it decides when a conversion begins and how long that conversion runs. It also decides which parts of the result the host may see on the data bus. A cycle counter stands in for the conversion time. The result comes from an abstract conversion engine and is captured when the counter expires.

A conversion starts at the moment the three start conditions first hold together: enable high, select low and read/convert low. Whichever of the three pins moves last supplies the qualifying edge. The byte-address line has two jobs. At the start it picks a long 12-bit cycle or a short 8-bit cycle. During a read it picks the high or the low half of the word.

The data bus is a plain pin-level read path with no handshake and no back-pressure. It has one output enable for each 4-bit nibble, so a narrow host can read a left-justified byte on the upper eight lines. The enables stand in for tri-state drivers.

Top module: `adc_ctrl_decode`

## Requirements
- R1: A conversion starts when (chip_en_i=1, chip_sel_n_i=0, rd_conv_i=0) changes from not-all-true to all-true. The change may come from a rising enable, a falling select or a falling read/convert. busy_o is high in the cycle after the clock edge that sees this.
- R2: The byte_addr_i value seen at the start sets the cycle length. A value of 0 keeps busy_o high for CYC_FULL_N clock cycles, and a value of 1 keeps it high for CYC_SHORT_N cycles.
- R3: A start condition that arises while busy_o is high is ignored. If that condition is still held when busy_o falls, it does not start a new conversion.
- R4: When busy_o falls, eng_result_i is captured as the result. After a short (8-bit) cycle, the 4 LSBs of the captured result are zero.
- R5: A read takes place only when chip_en_i=1, chip_sel_n_i=0, rd_conv_i=1 and busy_o=0. In every other case nib_oe_o=000 and data_o=0.
- R6: A read with word_mode_i=1 sets nib_oe_o=111 and places the full result on data_o. Bit i of nib_oe_o enables data_o[4i+3:4i].
- R7: A read with word_mode_i=0 and byte_addr_i=0 sets nib_oe_o=110 and places result[11:4] on data_o[11:4], with data_o[3:0]=0.
- R8: A read with word_mode_i=0 and byte_addr_i=1 sets nib_oe_o=110 and places result[3:0] on data_o[11:8], with zeros on data_o[7:0].
- R9: After reset, busy_o=0 and the stored result is 0.
- R10: While chip_en_i=0 or chip_sel_n_i=1, a movement of rd_conv_i starts nothing and enables no outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_en_i | input | 1 | Chip enable, active high |
| chip_sel_n_i | input | 1 | Chip select, active low |
| rd_conv_i | input | 1 | 1 = read, 0 = convert |
| word_mode_i | input | 1 | 1 = whole-word read, 0 = byte read |
| byte_addr_i | input | 1 | Cycle length at start, byte half at read |
| eng_result_i | input | 12 | Result from the conversion engine |
| busy_o | output | 1 | High while a conversion runs |
| data_o | output | 12 | Data bus value |
| nib_oe_o | output | 3 | Output enable for each data nibble |

## Verification
The bench starts a conversion through each of the three edges. A design that detected only the read/convert edge would never raise busy_o for the enable or select cases. It measures the busy time for both lengths, so a counter that is off by one or swaps the two lengths shows up as a wrong count. It drops read/convert again in mid-conversion and holds it there through the end of the conversion. A design that restarted or re-armed would stretch or repeat the busy time. The bench also reads every bus view, including one attempted while busy and ones with enable or select inactive. A lane swap, missing trailing zeros, or a bus driven during a conversion or without select all appear as wrong enables or data.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;

  typedef enum logic [1:0] {
    VIEW_NONE = 2'd0,
    VIEW_WORD = 2'd1,
    VIEW_HIGH = 2'd2,
    VIEW_LOW  = 2'd3
  } view_e;

  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;

endpackage

// File: rtl/adc_start_qual.sv
module adc_start_qual (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic sel_n_i,
  input  logic rdconv_i,
  input  logic busy_i,
  output logic start_o
);

  logic armed, armed_q;

  // all three start terms true together
  assign armed = en_i & ~sel_n_i & ~rdconv_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed;
  end

  // a start is the first cycle of the combined condition, outside a conversion
  assign start_o = armed & ~armed_q & ~busy_i;

  // R10: no start unless enabled and selected
  a_r10_no_start_unselected: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i || sel_n_i) |-> !start_o);

endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer import adc_ctrl_pkg::*; #(
  parameter int RES_W       = 12,
  parameter int CYC_FULL_N  = 14,
  parameter int CYC_SHORT_N = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             short_i,
  input  logic [RES_W-1:0] eng_i,
  output logic             busy_o,
  output logic [RES_W-1:0] res_o
);

  localparam int CNT_W = $clog2(CYC_FULL_N + 1);
  localparam int DROP_W = RES_W - BYTE_W;
  localparam logic [CNT_W-1:0] LOAD_FULL  = CNT_W'(CYC_FULL_N - 1);
  localparam logic [CNT_W-1:0] LOAD_SHORT = CNT_W'(CYC_SHORT_N - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, short_q;
  logic [RES_W-1:0] res_q, keep;

  assign keep = short_q ? {{BYTE_W{1'b1}}, {DROP_W{1'b0}}} : '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      short_q <= 1'b0;
      cnt_q   <= '0;
      res_q   <= '0;
    end else if (start_i && !busy_q) begin
      busy_q  <= 1'b1;
      short_q <= short_i;
      cnt_q   <= short_i ? LOAD_SHORT : LOAD_FULL;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_q <= 1'b0;
        res_q  <= eng_i & keep;
      end else begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  assign busy_o = busy_q;
  assign res_o  = res_q;

  // R1: a start raises busy on the next edge
  a_r1_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_q) |=> busy_q);

  // R3: a running count only steps down, never reloads
  a_r3_steady_count: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != '0) |=> (busy_q && cnt_q == $past(cnt_q) - CNT_W'(1)));

  // R4: short cycles end with cleared low bits
  a_r4_short_lsb_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_q) && short_q) |-> (res_q[DROP_W-1:0] == '0));

endmodule

// File: rtl/adc_bus_view.sv
module adc_bus_view import adc_ctrl_pkg::*; #(
  parameter int RES_W = 12
) (
  input  logic                   en_i,
  input  logic                   sel_n_i,
  input  logic                   rdconv_i,
  input  logic                   wide_i,
  input  logic                   addr_i,
  input  logic                   busy_i,
  input  logic [RES_W-1:0]       res_i,
  output logic [RES_W-1:0]       bus_o,
  output logic [RES_W/NIB_W-1:0] oe_o
);

  localparam int NIB    = RES_W / NIB_W;
  localparam int LANE_N = BYTE_W / NIB_W;
  localparam int DROP_W = RES_W - BYTE_W;

  view_e view;

  always_comb begin
    view = VIEW_NONE;
    if (en_i && !sel_n_i && rdconv_i && !busy_i) begin
      if (wide_i)      view = VIEW_WORD;
      else if (addr_i) view = VIEW_LOW;
      else             view = VIEW_HIGH;
    end
  end

  for (genvar i = 0; i < NIB; i++) begin : g_nib
    if (i >= NIB - LANE_N) begin : g_lane
      assign oe_o[i] = (view != VIEW_NONE);
    end else begin : g_tail
      assign oe_o[i] = (view == VIEW_WORD);
    end
  end

  always_comb begin
    unique case (view)
      VIEW_WORD: bus_o = res_i;
      VIEW_HIGH: bus_o = {res_i[RES_W-1:DROP_W], {DROP_W{1'b0}}};
      VIEW_LOW:  bus_o = {res_i[DROP_W-1:0], {(RES_W-DROP_W){1'b0}}};
      default:   bus_o = '0;
    endcase
  end

endmodule

// File: rtl/adc_ctrl_decode.sv
module adc_ctrl_decode import adc_ctrl_pkg::*; #(
  parameter int RES_W       = 12,
  parameter int CYC_FULL_N  = 14,
  parameter int CYC_SHORT_N = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   chip_en_i,
  input  logic                   chip_sel_n_i,
  input  logic                   rd_conv_i,
  input  logic                   word_mode_i,
  input  logic                   byte_addr_i,
  input  logic [RES_W-1:0]       eng_result_i,
  output logic                   busy_o,
  output logic [RES_W-1:0]       data_o,
  output logic [RES_W/NIB_W-1:0] nib_oe_o
);

  localparam int NIB    = RES_W / NIB_W;
  localparam int DROP_W = RES_W - BYTE_W;
  localparam logic [NIB-1:0] LANE_OE = {2'b11, {(NIB-2){1'b0}}};

  initial begin
    if (RES_W % NIB_W != 0 || RES_W <= BYTE_W || RES_W > 2 * BYTE_W)
      $error("RES_W must be a multiple of 4 between 12 and 16");
    if (CYC_SHORT_N < 1 || CYC_SHORT_N > CYC_FULL_N)
      $error("CYC_SHORT_N must lie in 1..CYC_FULL_N");
  end

  logic             start;
  logic [RES_W-1:0] res;

  adc_start_qual u_qual (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (chip_en_i),
    .sel_n_i  (chip_sel_n_i),
    .rdconv_i (rd_conv_i),
    .busy_i   (busy_o),
    .start_o  (start)
  );

  adc_conv_timer #(
    .RES_W       (RES_W),
    .CYC_FULL_N  (CYC_FULL_N),
    .CYC_SHORT_N (CYC_SHORT_N)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start),
    .short_i (byte_addr_i),
    .eng_i   (eng_result_i),
    .busy_o  (busy_o),
    .res_o   (res)
  );

  adc_bus_view #(.RES_W(RES_W)) u_view (
    .en_i     (chip_en_i),
    .sel_n_i  (chip_sel_n_i),
    .rdconv_i (rd_conv_i),
    .wide_i   (word_mode_i),
    .addr_i   (byte_addr_i),
    .busy_i   (busy_o),
    .res_i    (res),
    .bus_o    (data_o),
    .oe_o     (nib_oe_o)
  );

  // R1: busy only rises out of a cycle that saw the full start condition
  a_r1_start_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(chip_en_i && !chip_sel_n_i && !rd_conv_i));

  // R5: nothing is driven during a conversion
  a_r5_quiet_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (nib_oe_o == '0));

  // R6: only the three legal enable shapes appear
  a_r6_enable_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (nib_oe_o == '0) || (nib_oe_o == '1) || (nib_oe_o == LANE_OE));

  // R8: the low-byte view carries trailing zeros in the lane
  a_r8_low_trailing: assert property (@(posedge clk) disable iff (!rst_n)
    (nib_oe_o != '0 && !word_mode_i && byte_addr_i)
      |-> (data_o[RES_W-DROP_W-1:0] == '0));

endmodule

// File: tb/sim_adc_ctrl_decode.sv
`timescale 1ns/1ps
module sim_adc_ctrl_decode;

  localparam int FULL_N  = 14;
  localparam int SHORT_N = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, seln = 1'b1, rd = 1'b1, wide = 1'b1, addr = 1'b0;
  logic [11:0] eng = '0;
  logic busy;
  logic [11:0] data;
  logic [2:0] oe;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  adc_ctrl_decode #(.RES_W(12), .CYC_FULL_N(FULL_N), .CYC_SHORT_N(SHORT_N)) u0 (
    .clk(clk), .rst_n(rst_n), .chip_en_i(en), .chip_sel_n_i(seln),
    .rd_conv_i(rd), .word_mode_i(wide), .byte_addr_i(addr),
    .eng_result_i(eng), .busy_o(busy), .data_o(data), .nib_oe_o(oe)
  );

  typedef struct packed {
    logic en, seln, rd, wide, addr;
    logic [2:0] oe;
    logic [11:0] bus;
  } vec_t;

  // read views of the stored result 12'hA5C
  localparam vec_t VECS [8] = '{
    '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 3'b111, 12'hA5C},  // R6 word
    '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 3'b111, 12'hA5C},  // R6 word, addr ignored
    '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 3'b110, 12'hA50},  // R7 high byte
    '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 3'b110, 12'hC00},  // R8 low byte
    '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 3'b000, 12'h000},  // R5 disabled
    '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 3'b000, 12'h000},  // R5 deselected
    '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'b000, 12'h000},  // R10 rd falls, disabled
    '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 3'b000, 12'h000}   // R10 enable rises, deselected
  };

  function automatic string tag_of(input int i);
    case (i)
      0, 1: return "R6";
      2: return "R7";
      3: return "R8";
      4, 5: return "R5";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // kind 0: read/convert falls, 1: select falls, 2: enable rises
  task automatic do_conv(input int kind, input logic a, input logic [11:0] val,
                         input bit retrig, output int n);
    @(negedge clk);
    eng = val; addr = a; wide = 1'b1;
    case (kind)
      0: begin en = 1'b1; seln = 1'b0; rd = 1'b1; end
      1: begin en = 1'b1; seln = 1'b1; rd = 1'b0; end
      default: begin en = 1'b0; seln = 1'b0; rd = 1'b0; end
    endcase
    repeat (2) @(negedge clk);
    check("R10", busy, 1'b0);
    case (kind)
      0: rd = 1'b0;
      1: seln = 1'b0;
      default: en = 1'b1;
    endcase
    @(negedge clk);
    check("R1", busy, 1'b1);
    en = 1'b1; seln = 1'b0; rd = 1'b1;
    #1;
    check("R5", oe, 3'b000);
    n = 0;
    while (busy) begin
      n++;
      if (retrig && n == 3) begin rd = 1'b0; addr = 1'b1; end
      @(negedge clk);
    end
    if (retrig) begin
      repeat (2) @(negedge clk);
      check("R3", busy, 1'b0);
    end
    rd = 1'b1; addr = 1'b0; wide = 1'b1;
    #1;
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", busy, 1'b0);
    check("R9", oe, 3'b000);
    en = 1'b1; seln = 1'b0; rd = 1'b1; wide = 1'b1;
    #1;
    check("R9", data, 12'h000);

    // R1/R2/R4 via read/convert edge, long cycle
    do_conv(0, 1'b0, 12'h5E7, 1'b0, n);
    check("R2", n, FULL_N);
    check("R4", data, 12'h5E7);

    // R1/R2/R4 via select edge, short cycle with masked LSBs
    do_conv(1, 1'b1, 12'h3B7, 1'b0, n);
    check("R2", n, SHORT_N);
    check("R4", data, 12'h3B0);

    // R1 via enable edge
    do_conv(2, 1'b0, 12'h0F1, 1'b0, n);
    check("R2", n, FULL_N);
    check("R4", data, 12'h0F1);

    // R3: new falling edge in mid-conversion with the short address, held to the end
    do_conv(0, 1'b0, 12'h123, 1'b1, n);
    check("R3", n, FULL_N);
    check("R3", data, 12'h123);

    // result for the table
    do_conv(0, 1'b0, 12'hA5C, 1'b0, n);
    check("R4", data, 12'hA5C);

    foreach (VECS[i]) begin
      @(negedge clk);
      en = VECS[i].en; seln = VECS[i].seln; rd = VECS[i].rd;
      wide = VECS[i].wide; addr = VECS[i].addr;
      #1;
      check(tag_of(i), oe, VECS[i].oe);
      check(tag_of(i), data, VECS[i].bus);
      @(negedge clk);
      check(tag_of(i), busy, 1'b0);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule